// File: doc/BRIEF.md
# Register File with Selectable Program Counter

This block is the register file of a small sequencer. It has no dedicated program counter. It holds sixteen general registers of sixteen bits each, and a four-bit selector names the one that currently acts as the program counter. The named register drives the fetch address. Each fetch strobe then advances that register by one.

A controller changes the flow of control by writing registers and the selector. For a call, it loads the target address into a free register and points the selector at that register. For a return, it writes the selector back to the caller's index. The caller's register was left untouched while another register was selected, so it still holds the address at which the caller resumes.

The block also has a load port and a registered read port, so the controller can reach any register. Instruction decode, arithmetic and memory lie outside it.

Top module: `pc_select_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, the selector becomes 0 and all sixteen registers become 0. After reset, `sel_q` reads 0 and `fetch_addr` reads 0x0000.
- R2: `fetch_addr` always equals the current contents of the register whose index is `sel_q`.
- R3: When `fetch` is high at a rising edge, the selected register becomes its old value plus one, wrapping from 0xFFFF to 0x0000.
- R4: A fetch, a load or a selector write leaves every register it does not name unchanged.
- R5: When `ld_en` is high at a rising edge, register `ld_idx` takes `ld_data`.
- R6: If a load names the selected register in the same cycle as a fetch, the loaded value is kept and the increment is dropped.
- R7: When `sel_we` is high at a rising edge, `sel_q` takes `sel_data` and the next fetch uses it. A fetch in that same cycle uses, and advances, the register named by the old selector.
- R8: A call followed by a return works as follows. Load a target into register k and select k: `fetch_addr` then shows the target. Restore the old selector: `fetch_addr` then shows the caller's register, which holds its post-fetch value.
- R9: `rd_data` is a registered copy of register `rd_idx` as it stood before the rising edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch | input | 1 | Fetch strobe: advance the selected register |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Index of the register to load |
| ld_data | input | 16 | Value to load |
| sel_we | input | 1 | Selector write strobe |
| sel_data | input | 4 | New selector value |
| rd_idx | input | 4 | Index for the read port |
| fetch_addr | output | 16 | Contents of the selected register |
| sel_q | output | 4 | Current selector value |
| rd_data | output | 16 | Registered read of register `rd_idx` |

## Verification
The main stimulus is a stepped sequence in which straight-line fetches advance register 0. A call moves the fetch stream to a freshly loaded register, and a return shows that register 0 kept its resume address. This tells selection apart from a single shared counter.

Three cases in the sequence each test a separate decision. A fetch issued in the same cycle as a selector write distinguishes old-selector from new-selector timing. A load that coincides with a fetch on the selected register shows which of the two wins. A fetch from 0xFFFF checks the wrap to 0x0000.

Reads of registers that were never selected, and a reset issued mid-run, confirm that side registers are left alone and that everything clears.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;
  // Next-value source for one register of the bank
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_LOAD = 2'd2
  } upd_e;
endpackage

// File: rtl/pcsel_ctrl.sv
// Holds the selector and decodes per-register increment / load hits.
module pcsel_ctrl #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_data,
  output logic [IDX_W-1:0] sel_q,
  output logic [NREG-1:0]  inc_hit,
  output logic [NREG-1:0]  ld_hit
);
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_data;
  end

  // The fetch in this cycle uses the selector as it stands now
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign inc_hit[g] = fetch && (sel_q == IDX_W'(g));
    assign ld_hit[g]  = ld_en && (ld_idx == IDX_W'(g));
  end
endmodule

// File: rtl/pcsel_bank.sv
// The general register bank; each register has its own update rule.
module pcsel_bank
  import pcsel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              inc_hit,
  input  logic [NREG-1:0]              ld_hit,
  input  logic [DATA_W-1:0]            ld_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    upd_e upd;

    // A load outranks the fetch increment
    always_comb begin
      if (ld_hit[g])       upd = UPD_LOAD;
      else if (inc_hit[g]) upd = UPD_INC;
      else                 upd = UPD_HOLD;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else begin
        case (upd)
          UPD_LOAD: regs_q[g] <= ld_data;
          UPD_INC:  regs_q[g] <= regs_q[g] + ONE;
          default:  regs_q[g] <= regs_q[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/pcsel_port.sv
// Fetch-address mux and registered read port.
module pcsel_port #(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0][DATA_W-1:0] regs_q,
  input  logic [IDX_W-1:0]            sel_q,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           fetch_addr,
  output logic [DATA_W-1:0]           rd_data
);
  assign fetch_addr = regs_q[sel_q];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= regs_q[rd_idx];
  end
endmodule

// File: rtl/pc_select_regfile.sv
module pc_select_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              sel_we,
  input  logic [IDX_W-1:0]  sel_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] fetch_addr,
  output logic [IDX_W-1:0]  sel_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [NREG-1:0]              inc_hit;
  logic [NREG-1:0]              ld_hit;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;

  pcsel_ctrl #(.NREG(NREG), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .fetch(fetch), .ld_en(ld_en), .ld_idx(ld_idx),
    .sel_we(sel_we), .sel_data(sel_data), .sel_q(sel_q),
    .inc_hit(inc_hit), .ld_hit(ld_hit)
  );

  pcsel_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .inc_hit(inc_hit), .ld_hit(ld_hit),
    .ld_data(ld_data), .regs_q(regs_q)
  );

  pcsel_port #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_port (
    .clk(clk), .rst(rst), .regs_q(regs_q), .sel_q(sel_q), .rd_idx(rd_idx),
    .fetch_addr(fetch_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/pcsel_checker.sv
module pcsel_checker #(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch,
  input logic              ld_en,
  input logic [IDX_W-1:0]  ld_idx,
  input logic [DATA_W-1:0] ld_data,
  input logic              sel_we,
  input logic [IDX_W-1:0]  sel_data,
  input logic [DATA_W-1:0] fetch_addr,
  input logic [IDX_W-1:0]  sel_q
);
  logic armed = 1'b0;
  logic after_rst = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    after_rst <= rst;
  end

  // R1: first cycle out of reset shows selector 0 and address 0
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    after_rst |-> (sel_q == '0 && fetch_addr == '0));

  // R3: plain fetch advances the fetch address by one
  p_fetch_inc_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (fetch && !sel_we && !(ld_en && ld_idx == sel_q))
      |=> fetch_addr == $past(fetch_addr) + DATA_W'(1));

  // R4: no command leaves the fetch address unchanged
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!fetch && !sel_we && !ld_en) |=> $stable(fetch_addr));

  // R6: load to the selected register beats the increment
  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    (ld_en && ld_idx == sel_q && !sel_we) |=> fetch_addr == $past(ld_data));

  // R7: selector write lands on the next cycle
  p_sel_write_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    sel_we |=> sel_q == $past(sel_data));
endmodule

bind pc_select_regfile pcsel_checker #(
  .DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)
) u_pcsel_checker (
  .clk(clk), .rst(rst), .fetch(fetch), .ld_en(ld_en), .ld_idx(ld_idx),
  .ld_data(ld_data), .sel_we(sel_we), .sel_data(sel_data),
  .fetch_addr(fetch_addr), .sel_q(sel_q)
);

// File: tb/tb_pc_select_regfile.sv
module tb_pc_select_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch = 1'b0, ld_en = 1'b0, sel_we = 1'b0;
  logic [3:0]  ld_idx = '0, sel_data = '0, rd_idx = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] fetch_addr, rd_data;
  logic [3:0]  sel_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pc_select_regfile dut (
    .clk(clk), .rst(rst), .fetch(fetch), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .sel_we(sel_we), .sel_data(sel_data), .rd_idx(rd_idx),
    .fetch_addr(fetch_addr), .sel_q(sel_q), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        fe;
    logic        ld;
    logic [3:0]  li;
    logic [15:0] ldv;
    logic        sw;
    logic [3:0]  sd;
    logic [15:0] exp_fa;   // fetch_addr before this row's edge
    logic [3:0]  exp_sel;  // sel_q before this row's edge
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000, 4'd0}, // R3 fetch r0
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0001, 4'd0}, // R3
    '{1'b0, 1'b1, 4'd5, 16'h1000, 1'b0, 4'd0, 16'h0002, 4'd0}, // R5 load r5
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b1, 4'd5, 16'h0002, 4'd0}, // R7 fetch old sel, call
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h1000, 4'd5}, // R8 target shown
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h1001, 4'd5}, // R3
    '{1'b0, 1'b0, 4'd0, 16'h0000, 1'b1, 4'd0, 16'h1002, 4'd5}, // R8 return
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0003, 4'd0}, // R8 caller resumes, R4
    '{1'b1, 1'b1, 4'd0, 16'h0200, 1'b0, 4'd0, 16'h0004, 4'd0}, // R6 collision
    '{1'b0, 1'b1, 4'd7, 16'hFFFF, 1'b0, 4'd0, 16'h0200, 4'd0}, // R6 result, load r7
    '{1'b0, 1'b0, 4'd0, 16'h0000, 1'b1, 4'd7, 16'h0200, 4'd0}, // R7
    '{1'b1, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'hFFFF, 4'd7}, // R3 wrap
    '{1'b0, 1'b0, 4'd0, 16'h0000, 1'b0, 4'd0, 16'h0000, 4'd7}  // R3 wrapped
  };

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch = 1'b0; ld_en = 1'b0; sel_we = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] idx, input logic [15:0] exp, input string req);
    @(negedge clk);
    idle();
    rd_idx = idx;
    @(negedge clk);
    #1 chk16(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk16("R1 sel_q", {12'd0, sel_q}, 16'd0);
    chk16("R1 fetch_addr", fetch_addr, 16'd0);

    foreach (VEC[i]) begin
      @(negedge clk);
      fetch = VEC[i].fe; ld_en = VEC[i].ld; ld_idx = VEC[i].li;
      ld_data = VEC[i].ldv; sel_we = VEC[i].sw; sel_data = VEC[i].sd;
      #1;
      chk16($sformatf("R2 row %0d fetch_addr", i), fetch_addr, VEC[i].exp_fa);
      chk16($sformatf("R7 row %0d sel_q", i), {12'd0, sel_q}, {12'd0, VEC[i].exp_sel});
    end

    // Directed: read port and untouched registers
    read_reg(4'd5, 16'h1002, "R9 r5");
    read_reg(4'd0, 16'h0200, "R4 r0 kept while r7 selected");
    read_reg(4'd3, 16'h0000, "R4 r3 never named");
    read_reg(4'd7, 16'h0000, "R9 r7 after wrap");

    // Load a non-selected register during a fetch
    @(negedge clk);
    fetch = 1'b1; ld_en = 1'b1; ld_idx = 4'd2; ld_data = 16'hABCD;
    read_reg(4'd2, 16'hABCD, "R5 r2 loaded");
    #0 chk16("R4 selected advanced once", fetch_addr, 16'h0001);

    // Mid-run reset
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk16("R1 sel_q after reset", {12'd0, sel_q}, 16'd0);
    chk16("R1 fetch_addr after reset", fetch_addr, 16'd0);
    read_reg(4'd5, 16'h0000, "R1 r5 cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule